// File: doc/BRIEF.md
# Millisecond Interval Timer

This block raises a periodic interrupt whose period is a whole number of milliseconds. A prescaler divides the system clock into a one-cycle enable once per millisecond. A down counter loaded from a software reload value counts those enables. When the counter runs out it raises the interrupt line and reloads itself for the next period, with no help from software.

Software uses a small register window with two word addresses. Writing the reload word sets a new period and restarts timing from that moment. Reading the count word acknowledges the interrupt. The clock frequency is a parameter, and the number of clocks in one millisecond is derived from it.

The bus is synchronous. A request is sampled on a rising edge while `bus_sel` is high. Read data appears, together with `bus_rvalid`, one cycle after the request.

Top module: `ms_interval_timer`

## Requirements
- R1: With reload value R, the interrupt rises DIV*(R+1) clock edges after the edge that sampled the reload write, where DIV = CLK_HZ/1000 clocks per millisecond.
- R2: After each expiry the counter re-arms by itself, so expiries keep coming every (R+1) ms without any software access.
- R3: A write to the reload word (address 0) lowers the interrupt at the sampling edge and restarts the period from zero. An expiry that would fall on that same edge is dropped.
- R4: A read of the count word (address 1) returns 0 with `bus_rvalid` one cycle later, and lowers the interrupt at the sampling edge.
- R5: After reset the reload value is 0 and the interrupt is low, and the first expiry comes DIV edges after reset is released.
- R6: Once high, the interrupt stays high until a count read or a reload write. Further expiries leave it high.
- R7: When a count read and an expiry fall on the same edge, the expiry wins and the interrupt is high afterwards.
- R8: Only the low RELOAD_W bits of a reload write are kept. A read of the reload word returns them zero-extended and does not touch the interrupt. A write to the count word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request valid, sampled on the rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: 0 = reload, 1 = count |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle after a read request |
| irq | output | 1 | Level interrupt, set on expiry |

## Verification
Two pairs of events can fall on the same clock edge: an expiry together with a count-read acknowledge, and an expiry together with a reload write. The bench computes the exact edge of each expiry from the period formula and places each bus request so that it is sampled on that edge. In the first pair the interrupt must remain set and the monitor must record a rise at that edge. In the second pair the interrupt must stay low until one full new period has passed, and a leaked expiry would show up as an unexpected rise in the scoreboard.

// File: rtl/ms_timer_pkg.sv
package ms_timer_pkg;

  localparam int unsigned ADDR_RELOAD = 0;
  localparam int unsigned ADDR_COUNT  = 1;

  // clocks per millisecond, never below 2 so a tick is a single-cycle pulse
  function automatic int unsigned clocks_per_ms(input int unsigned clk_hz);
    int unsigned d;
    d = clk_hz / 1000;
    return (d < 2) ? 2 : d;
  endfunction

  // width of a counter that must hold values 0 .. n-1
  function automatic int unsigned count_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
  parameter int unsigned DIV = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = ms_timer_pkg::count_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= '0;
    else              phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ms_period_counter.sv
module ms_period_counter #(
  parameter int unsigned RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                restart,
  input  logic [RELOAD_W-1:0] reload_new,
  input  logic [RELOAD_W-1:0] reload_cur,
  output logic                expire
);
  logic [RELOAD_W-1:0] remaining;

  function automatic logic [RELOAD_W-1:0] next_remaining(
    input logic [RELOAD_W-1:0] rem,
    input logic [RELOAD_W-1:0] rld
  );
    return (rem == '0) ? rld : rem - 1'b1;
  endfunction

  assign expire = tick && (remaining == '0) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       remaining <= '0;
    else if (restart) remaining <= reload_new;
    else if (tick)    remaining <= next_remaining(remaining, reload_cur);
  end
endmodule

// File: rtl/ms_timer_regs.sv
module ms_timer_regs #(
  parameter int unsigned RELOAD_W = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [RELOAD_W-1:0] wdata_low,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic [RELOAD_W-1:0] reload_val,
  output logic                reload_write,
  output logic                count_ack
);
  import ms_timer_pkg::*;

  logic hit_reload, hit_count;

  assign hit_reload   = (bus_addr == ADDR_W'(ADDR_RELOAD));
  assign hit_count    = (bus_addr == ADDR_W'(ADDR_COUNT));
  assign reload_write = bus_sel && bus_we && hit_reload;
  assign count_ack    = bus_sel && !bus_we && hit_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            reload_val <= '0;
    else if (reload_write) reload_val <= wdata_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_sel && !bus_we;
      if (bus_sel && !bus_we)
        bus_rdata <= hit_reload ? DATA_W'(reload_val) : '0;
    end
  end
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer #(
  parameter int unsigned CLK_HZ   = 250000000,
  parameter int unsigned RELOAD_W = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  localparam int unsigned DIV = ms_timer_pkg::clocks_per_ms(CLK_HZ);

  // named internal events, also observed by the bound checker
  logic                ms_tick;
  logic                period_expire;
  logic                reload_write;
  logic                count_ack;
  logic [RELOAD_W-1:0] reload_val;

  generate
    if (DATA_W > RELOAD_W) begin : g_drop_high
      logic unused_high;
      assign unused_high = ^bus_wdata[DATA_W-1:RELOAD_W];
    end
  endgenerate

  ms_timer_regs #(.RELOAD_W(RELOAD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .wdata_low   (bus_wdata[RELOAD_W-1:0]),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .reload_val  (reload_val),
    .reload_write(reload_write),
    .count_ack   (count_ack)
  );

  ms_prescaler #(.DIV(DIV)) presc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(reload_write),
    .tick   (ms_tick)
  );

  ms_period_counter #(.RELOAD_W(RELOAD_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (ms_tick),
    .restart   (reload_write),
    .reload_new(bus_wdata[RELOAD_W-1:0]),
    .reload_cur(reload_val),
    .expire    (period_expire)
  );

  // restart clears; expiry beats a count acknowledge on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             irq <= 1'b0;
    else if (reload_write)  irq <= 1'b0;
    else if (period_expire) irq <= 1'b1;
    else if (count_ack)     irq <= 1'b0;
  end
endmodule

// File: rtl/ms_interval_timer_chk.sv
module ms_interval_timer_chk #(
  parameter int unsigned CLK_HZ   = 250000000,
  parameter int unsigned RELOAD_W = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                bus_rvalid,
  input logic                irq,
  input logic                ms_tick,
  input logic                period_expire,
  input logic                reload_write,
  input logic                count_ack,
  input logic [RELOAD_W-1:0] reload_val
);
  logic [RELOAD_W:0] ticks_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ticks_seen <= '0;
    else if (reload_write || period_expire) ticks_seen <= '0;
    else if (ms_tick)                       ticks_seen <= ticks_seen + 1'b1;
  end

  // R1: an expiry comes on the (R+1)th millisecond tick of a period
  p_period_length_r1: assert property (@(posedge clk) disable iff (!rst_n)
    period_expire |-> (ticks_seen == {1'b0, reload_val}));

  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |=> !ms_tick);

  // R2: an expiry sets the interrupt
  p_expire_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_expire |=> irq);

  p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(period_expire));

  // R3: a reload write leaves the interrupt low
  p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(ms_timer_pkg::ADDR_RELOAD)) |=> !irq);

  // R4: a count read answers zero one cycle later
  p_count_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == ADDR_W'(ms_timer_pkg::ADDR_COUNT))
      |=> (bus_rvalid && bus_rdata == '0));

  // R6: the interrupt holds until it is acknowledged or restarted
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !count_ack && !reload_write) |=> irq);

  // R7: an expiry beats an acknowledge on the same edge
  p_expire_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_expire && count_ack) |=> irq);
endmodule

bind ms_interval_timer ms_interval_timer_chk #(
  .CLK_HZ(CLK_HZ), .RELOAD_W(RELOAD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .bus_rvalid   (bus_rvalid),
  .irq          (irq),
  .ms_tick      (ms_tick),
  .period_expire(period_expire),
  .reload_write (reload_write),
  .count_ack    (count_ack),
  .reload_val   (reload_val)
);

// File: tb/ms_interval_timer_tb_top.sv
`timescale 1ns/1ps
module ms_interval_timer_tb_top;
  localparam int unsigned CLK_HZ = 10000;   // 10 clocks per millisecond
  localparam int MS = 10;

  typedef struct {
    int    edge_no;
    string tag;
  } rise_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int    cyc;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  rise_t expq[$];

  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  ms_interval_timer #(.CLK_HZ(CLK_HZ), .RELOAD_W(16), .DATA_W(32), .ADDR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected interrupt rise, by edge number
  task automatic expect_rise(input int e, input string tag);
    rise_t r;
    r.edge_no = e;
    r.tag = tag;
    expq.push_back(r);
  endtask

  task automatic wait_edge(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  // present a request so that it is sampled on edge e; returns at the negedge after e
  task automatic bus_at(input int e, input logic we, input logic [1:0] a,
                        input logic [31:0] d);
    while (cyc < e - 1) @(negedge clk);
    check(cyc == e - 1, "schedule", cyc, e - 1);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pop and compare on every observed rise
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (irq && !prev) begin
          if (expq.size() == 0) begin
            check(1'b0, "R3 unexpected rise", cyc, 0);
          end else begin
            rise_t r;
            r = expq.pop_front();
            check(cyc == r.edge_no, r.tag, cyc, r.edge_no);
          end
        end
        prev = irq;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R5 irq low in reset", irq, 0);
    check(bus_rvalid == 1'b0, "R5 no response in reset", bus_rvalid, 0);
    expect_rise(MS, "R5 first expiry after 1 ms");
    rst_n = 1'b1;

    bus_at(3, 1'b0, 2'd0, 0);
    check(bus_rvalid && bus_rdata == 0, "R5 reload resets to 0", bus_rdata, 0);

    // R4: acknowledge by count read
    bus_at(15, 1'b0, 2'd1, 0);
    check(bus_rvalid && bus_rdata == 0, "R4 count reads zero", bus_rdata, 0);
    check(irq == 1'b0, "R4 read lowers irq", irq, 0);
    expect_rise(2 * MS, "R2 automatic re-arm");

    // R6: expiry at 30 finds irq already high
    wait_edge(35);
    check(irq == 1'b1, "R6 irq held without ack", irq, 1);

    // R8: writing the count word changes nothing
    bus_at(36, 1'b1, 2'd1, 32'h0000_0005);
    check(irq == 1'b1, "R8 count write ignored", irq, 1);
    bus_at(41, 1'b0, 2'd1, 0);
    check(irq == 1'b0, "R4 ack after ignored write", irq, 0);
    expect_rise(5 * MS, "R8 period unchanged by count write");

    // R3/R8: reload write with high bits set -> R = 2
    bus_at(53, 1'b1, 2'd0, 32'hFFFF_0002);
    check(irq == 1'b0, "R3 reload write lowers irq", irq, 1'b0);
    expect_rise(53 + 3 * MS, "R1 period of 3 ms after write");
    bus_at(55, 1'b0, 2'd0, 0);
    check(bus_rdata == 32'd2, "R8 reload readback truncated", bus_rdata, 2);

    wait_edge(85);
    bus_at(86, 1'b0, 2'd0, 0);
    check(irq == 1'b1, "R8 reload read does not ack", irq, 1);
    bus_at(88, 1'b0, 2'd1, 0);
    check(irq == 1'b0, "R4 ack", irq, 0);

    // R7: count read on the expiry edge 113
    expect_rise(113, "R7 expiry beats ack");
    bus_at(113, 1'b0, 2'd1, 0);
    check(irq == 1'b1, "R7 irq high after simultaneous ack", irq, 1);
    check(bus_rdata == 0, "R4 count reads zero", bus_rdata, 0);
    bus_at(120, 1'b0, 2'd1, 0);
    check(irq == 1'b0, "R4 ack", irq, 0);

    // R3: reload write on the expiry edge 143 drops that expiry
    expect_rise(143 + MS, "R3 restart after dropped expiry");
    bus_at(143, 1'b1, 2'd0, 0);
    check(irq == 1'b0, "R3 expiry dropped on write edge", irq, 0);
    wait_edge(152);
    check(irq == 1'b0, "R3 still low before new period", irq, 0);
    wait_edge(160);
    check(irq == 1'b1, "R1 one-ms period after write", irq, 1);
    check(expq.size() == 0, "R2 all expected rises seen", expq.size(), 0);
    finish_run();
  end
endmodule